// File: doc/BRIEF.md
# Latched Real-Time Clock Register Block

This block keeps a running wall-clock time (seconds, minutes, hours and a 9-bit day count) in its own counting clock domain. A prescaler divides the counting clock (`rtc_clk`) down to a once-per-second advance. The CPU, clocked by `clk`, never reads the live counters. It first asks for a snapshot through a control register, which copies every field in the same counting cycle. It then reads the frozen copy one byte at a time through five register codes.

CPU writes to the control register and to the counter registers are captured in the CPU domain and handed over with a toggle handshake. A synchronizer carries the toggle into the counting domain, and the write takes effect there in one cycle. A counter update and a CPU write therefore never race. A write always takes priority over a same-cycle advance. The cost of this is that the software must leave at least four CPU cycles between consecutive accesses to the control or counter registers.

Top module: `rtc_latch_regs`

## Requirements
- R1: `cpu_rdata` shows the snapshot byte chosen by the select register. The codes are 08h seconds, 09h minutes, 0Ah hours, 0Bh day bits 7:0, and 0Ch the day-high register. In the day-high register, bit 0 is day bit 8, bit 6 is halt, bit 7 is day carry, and the other bits read 0. Field values are zero-extended. Any other select value reads FFh.
- R2: A write of `cpu_space`=01 (control) with data 01h, immediately preceded by a control write of 00h, copies all live fields into the snapshot at once. The snapshot holds its value in every other case, including a repeated 01h.
- R3: On each advance, seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0, and each wrap carries into the next field.
- R4: The day count wraps from 511 to 0 and sets the day carry (bit 7 of 0Ch). The carry stays set until a CPU write to 0Ch clears it.
- R5: While halt (bit 6 of 0Ch) is set, no field advances and the prescaler holds.
- R6: A CPU write with `cpu_space`=10 (data) loads the live field chosen by the current select code, and restarts the prescaler. The next advance therefore comes a full PRESCALE counting cycles later.
- R7: Each CPU write with `cpu_space`=01 or 10 takes effect exactly once in the counting domain, and it takes priority over a same-cycle advance. `cpu_space`=00 writes the select register, and `cpu_space`=11 is ignored.
- R8: After reset, the select register is 00h, and the live counters, the flags and the snapshot are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| rtc_clk | input | 1 | Counting-domain clock, divided by PRESCALE to one second |
| cpu_we | input | 1 | CPU write strobe, one `clk` cycle |
| cpu_space | input | 2 | Target: 00 select, 01 control, 10 counter data, 11 none |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Snapshot byte for the current select code |

## Verification
The assertions assume the CPU leaves at least four CPU cycles between writes. They also assume the counting clock is fast enough that each handed-over write is applied before the next one arrives, and that written field values stay within range (seconds and minutes below 60, hours below 24). The bench drives every write as a one-cycle strobe followed by five idle cycles, and it runs the counting clock faster than the CPU clock. It draws random field values only from the legal ranges, weighted toward the wrap values 59, 23 and 511. Snapshot commands are timed half a second away from any advance, so sampling stays clear of the handover latency.

// File: rtl/rtc_latch_regs.sv
`timescale 1ns/1ps
module rtc_latch_regs #(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_clk,
  input  logic       cpu_we,
  input  logic [1:0] cpu_space,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [7:0] sel_q, req_code, req_data;
  logic       req_ctl, req_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      req_code <= '0;
      req_data <= '0;
      req_ctl  <= 1'b0;
      req_t    <= 1'b0;
    end else if (cpu_we) begin
      case (cpu_space)
        2'b00: sel_q <= cpu_wdata;
        2'b01: begin
          req_ctl  <= 1'b1;
          req_data <= cpu_wdata;
          req_t    <= ~req_t;
        end
        2'b10: begin
          req_ctl  <= 1'b0;
          req_code <= sel_q;
          req_data <= cpu_wdata;
          req_t    <= ~req_t;
        end
        default: ;
      endcase
    end
  end

  logic [2:0] tsync;
  always_ff @(posedge rtc_clk or negedge rst_n)
    if (!rst_n) tsync <= '0;
    else        tsync <= {tsync[1:0], req_t};

  logic apply, ctl_wr, cnt_wr, latch_fire;
  logic [7:0] ctl_prev;
  assign apply      = tsync[2] ^ tsync[1];
  assign ctl_wr     = apply & req_ctl;
  assign cnt_wr     = apply & ~req_ctl & (req_code >= 8'h08) & (req_code <= 8'h0C);
  assign latch_fire = ctl_wr & (ctl_prev == 8'h00) & (req_data == 8'h01);

  logic [PW-1:0] pre;
  logic [5:0]    sec, min;
  logic [4:0]    hr;
  logic [8:0]    day;
  logic          halt, carry, tick;
  logic          sec_w, min_w, hr_w;

  assign tick  = ~halt & (pre == PRE_LAST);
  assign sec_w = sec == 6'd59;
  assign min_w = min == 6'd59;
  assign hr_w  = hr == 5'd23;

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      sec   <= '0;
      min   <= '0;
      hr    <= '0;
      day   <= '0;
      halt  <= 1'b0;
      carry <= 1'b0;
    end else if (cnt_wr) begin
      pre <= '0;
      case (req_code[2:0])
        3'd0: sec <= req_data[5:0];
        3'd1: min <= req_data[5:0];
        3'd2: hr  <= req_data[4:0];
        3'd3: day[7:0] <= req_data;
        default: begin
          day[8] <= req_data[0];
          halt   <= req_data[6];
          carry  <= req_data[7];
        end
      endcase
    end else if (!halt) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        sec <= sec_w ? 6'd0 : sec + 6'd1;
        if (sec_w) min <= min_w ? 6'd0 : min + 6'd1;
        if (sec_w && min_w) hr <= hr_w ? 5'd0 : hr + 5'd1;
        if (sec_w && min_w && hr_w) begin
          day <= day + 9'd1;
          if (day == 9'd511) carry <= 1'b1;
        end
      end
    end
  end

  logic [4:0][7:0] live, snap;
  assign live = {{carry, halt, 5'b0, day[8]}, day[7:0], {3'b0, hr}, {2'b0, min}, {2'b0, sec}};

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_prev <= '0;
      snap     <= '0;
    end else begin
      if (ctl_wr)     ctl_prev <= req_data;
      if (latch_fire) snap     <= live;
    end
  end

  assign cpu_rdata = (sel_q >= 8'h08 && sel_q <= 8'h0C) ? snap[sel_q[2:0]] : 8'hFF;
endmodule

// File: rtl/rtc_latch_regs_checker.sv
`timescale 1ns/1ps
module rtc_latch_regs_checker #(
  parameter int PW = 15
) (
  input logic            rtc_clk,
  input logic            rst_n,
  input logic            tick,
  input logic            apply,
  input logic            cnt_wr,
  input logic            latch_fire,
  input logic [7:0]      req_code,
  input logic [PW-1:0]   pre,
  input logic [5:0]      sec,
  input logic [5:0]      min,
  input logic [4:0]      hr,
  input logic [8:0]      day,
  input logic            halt,
  input logic            carry,
  input logic [39:0]     snap
);
  p_range_r3: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    sec < 6'd60 && min < 6'd60 && hr < 5'd24);

  p_sec_step_r3: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> sec == (($past(sec) == 6'd59) ? 6'd0 : $past(sec) + 6'd1));

  p_carry_sticky_r4: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (carry && !(cnt_wr && req_code == 8'h0C)) |=> carry);

  p_halt_hold_r5: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    (halt && !cnt_wr) |=> ($stable(sec) && $stable(min) && $stable(hr) && $stable(day) && $stable(pre)));

  p_pre_restart_r6: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    cnt_wr |=> pre == '0);

  p_snap_hold_r2: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    !latch_fire |=> $stable(snap));

  p_single_apply_r7: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    apply |=> !apply);
endmodule

bind rtc_latch_regs rtc_latch_regs_checker #(.PW(PW)) u_chk (
  .rtc_clk(rtc_clk), .rst_n(rst_n), .tick(tick), .apply(apply), .cnt_wr(cnt_wr),
  .latch_fire(latch_fire), .req_code(req_code), .pre(pre), .sec(sec), .min(min),
  .hr(hr), .day(day), .halt(halt), .carry(carry), .snap(snap)
);

// File: tb/rtc_latch_regs_tb.sv
`timescale 1ns/1ps
module rtc_latch_regs_tb;
  localparam int PRESCALE = 40;   // 40 x 3 ns = 120 ns = 15 CPU cycles per second

  logic clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_space = 2'b00;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;
  always #1.5 rtc_clk = ~rtc_clk;

  rtc_latch_regs #(.PRESCALE(PRESCALE)) u_dut (
    .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .cpu_we(cpu_we),
    .cpu_space(cpu_space), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sp, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_space = sp; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] code, output logic [7:0] v);
    wr(2'b00, code);
    v = cpu_rdata;
  endtask

  function automatic void adv(inout int s, inout int m, inout int h, inout int d,
                              inout int c, input int n);
    for (int i = 0; i < n; i++) begin
      if (s == 59) begin
        s = 0;
        if (m == 59) begin
          m = 0;
          if (h == 23) begin
            h = 0;
            if (d == 511) begin d = 0; c = 1; end
            else d++;
          end else h++;
        end else m++;
      end else s++;
    end
  endfunction

  task automatic read_all(input int s, input int m, input int h, input int d,
                          input int c, input int hl, input string tag);
    logic [7:0] v;
    rd(8'h08, v); check(v, 8'(s), {tag, " sec"});
    rd(8'h09, v); check(v, 8'(m), {tag, " min"});
    rd(8'h0A, v); check(v, 8'(h), {tag, " hour"});
    rd(8'h0B, v); check(v, 8'(d & 255), {tag, " daylo"});
    rd(8'h0C, v); check(v, {c[0], hl[0], 5'b0, d[8]}, {tag, " dayhi"});
  endtask

  // write a time with halt set, release it, let n seconds pass, then latch mid-second
  task automatic run_case(input int s, input int m, input int h, input int d,
                          input int c, input int n, input string tag);
    int es = s, em = m, eh = h, ed = d, ec = c;
    wr(2'b01, 8'h00);
    wr(2'b00, 8'h0C); wr(2'b10, 8'h40);
    wr(2'b00, 8'h08); wr(2'b10, 8'(s));
    wr(2'b00, 8'h09); wr(2'b10, 8'(m));
    wr(2'b00, 8'h0A); wr(2'b10, 8'(h));
    wr(2'b00, 8'h0B); wr(2'b10, 8'(d & 255));
    wr(2'b00, 8'h0C);
    wr(2'b10, {c[0], 6'b0, d[8]});
    repeat (15 * n + 1) @(negedge clk);
    wr(2'b01, 8'h01);
    adv(es, em, eh, ed, ec, n);
    read_all(es, em, eh, ed, ec, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_rdata, 8'hFF, "R8 select resets to 00h, R1 unmapped reads FFh");
    read_all(0, 0, 0, 0, 0, 0, "R8 reset snapshot zero");
    rd(8'h0D, v); check(v, 8'hFF, "R1 code 0Dh unmapped");
    rd(8'h07, v); check(v, 8'hFF, "R1 code 07h unmapped");

    run_case(59, 10, 5, 3, 0, 1, "R3 second wrap");
    run_case(59, 59, 22, 7, 0, 1, "R3 minute and hour carry");
    run_case(59, 59, 23, 255, 0, 1, "R3 day into bit 8");
    run_case(59, 59, 23, 511, 0, 1, "R4 day overflow sets carry");
    run_case(58, 59, 23, 511, 1, 3, "R4 carry stays after overflow");
    run_case(12, 30, 4, 100, 0, 0, "R6 no advance before full second");

    // R4: a write of 0Ch with bit 7 clear removes the carry
    wr(2'b01, 8'h00);
    wr(2'b00, 8'h0C); wr(2'b10, 8'h40);
    wr(2'b01, 8'h01);
    rd(8'h0C, v); check(v, 8'h40, "R4 carry cleared by write, R5 halt bit reads back");

    // R5: halted clock does not advance
    wr(2'b00, 8'h08); wr(2'b10, 8'd59);
    wr(2'b01, 8'h00);
    repeat (100) @(negedge clk);
    wr(2'b01, 8'h01);
    read_all(59, 30, 4, 100, 0, 1, "R5 halted");

    // R2: snapshot frozen without a new 00h/01h sequence
    wr(2'b00, 8'h0C); wr(2'b10, 8'h00);
    repeat (60) @(negedge clk);
    read_all(59, 30, 4, 100, 0, 1, "R2 frozen after time passed");
    wr(2'b01, 8'h01);
    read_all(59, 30, 4, 100, 0, 1, "R2 repeated 01h ignored");
    wr(2'b11, 8'h55);
    wr(2'b01, 8'h02);
    wr(2'b01, 8'h01);
    read_all(59, 30, 4, 100, 0, 1, "R7 space 11 ignored, R2 02h then 01h no latch");

    // R6: a seconds write while running restarts the prescaler
    run_case(0, 0, 0, 0, 0, 2, "R7 restart point");
    wr(2'b01, 8'h00);
    repeat (5) @(negedge clk);
    wr(2'b00, 8'h08);
    wr(2'b10, 8'd20);
    repeat (7) @(negedge clk);
    wr(2'b01, 8'h01);
    rd(8'h08, v); check(v, 8'd20, "R6 prescaler restarted by write");

    for (int i = 0; i < 24; i++) begin
      int s, m, h, d, c, n;
      s = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
      m = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
      h = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
      d = ($urandom % 4 == 0) ? 511 : int'($urandom % 512);
      c = int'($urandom % 2);
      n = int'($urandom % 4);
      run_case(s, m, h, d, c, n, "R3 R4 R7 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule